// File: doc/BRIEF.md
# Frame-Addressed Configuration Memory Loader

This block holds the configuration state of a programmable fabric as a set of equal-width frames and fills them from a single serial line. A shift register, the frame buffer, collects a string of bits one per enabled clock. The string carries the frame payload first and the target frame number last. A write strobe then copies the payload from the buffer, in parallel, into the one frame that the frame number selects.

The payload side of the buffer drives one shared bus that reaches every frame. A decoder turns the frame number and the strobe into at most one load enable, so only the chosen frame captures the bus. Every frame is presented at all times on a flat output vector for the logic it configures. A separate clear input wipes all frames at once. Reset empties only the buffer, so a reset during operation does not disturb a loaded configuration.

Top module: `cfgmem_loader`

## Requirements
- R1: While `shift_en` is high, each clock moves the buffer one place toward its high end and enters `shift_in` at bit 0. After FRAME_BITS+ADDR_W shifts, the first payload bit shifted in sits at frame bit FRAME_BITS-1 and the last at frame bit 0. The following ADDR_W bits form the frame number, most significant bit first. ADDR_W is ceil(log2(NUM_FRAMES)), with a minimum of 1. With `shift_en` low, the buffer holds its value.
- R2: A clock with `write_en` high, `clear_all` low and a frame number below NUM_FRAMES stores the buffered payload into that frame. The new value appears on `cfg_out` after that edge. Frame k occupies `cfg_out[k*FRAME_BITS +: FRAME_BITS]`.
- R3: A single write loads at most one frame.
- R4: A frame that is not addressed by a write keeps its contents, except when `clear_all` is high.
- R5: A write whose frame number is NUM_FRAMES or higher changes no frame.
- R6: `clear_all` zeroes every frame on the next edge. It takes priority over a write in the same cycle.
- R7: `rst` zeroes the frame buffer and leaves every frame's contents unchanged.
- R8: When a write and a shift happen in the same cycle, the write uses the buffer contents from before that shift, and the buffer still shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the frame buffer |
| shift_en | input | 1 | Enables one serial shift per clock |
| shift_in | input | 1 | Serial configuration bit |
| write_en | input | 1 | Copies the buffered payload into the addressed frame |
| clear_all | input | 1 | Zeroes every frame |
| cfg_out | output | NUM_FRAMES*FRAME_BITS | All frames side by side, frame 0 in the low bits |

## Verification
The bench loads a different pattern into each of the six frames and reads all of them back. A decoder that aliases addresses or loads the wrong frame would leave a stale or overwritten neighbour. Frame numbers 6 and 7 exist in the three-bit field but name no frame. The bench writes to both, which shows a decoder that wraps or truncates the frame number. A write coinciding with a shift must take the pre-shift payload, and a clear coinciding with a write must win, so an implementation that orders these the other way leaves a detectable mismatch. A reset between loads must leave the frames intact while emptying the buffer, which the bench exposes by writing the emptied buffer to frame 0.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

    // Width of the frame-number field for a given frame count (at least one bit).
    function automatic int frame_addr_width(input int frames);
        return (frames > 1) ? $clog2(frames) : 1;
    endfunction

    // Per-cycle control applied to the loader.
    typedef struct packed {
        logic shift;
        logic bit_in;
        logic write;
        logic clear;
    } cfg_op_t;

endpackage

// File: rtl/cfgmem_frame_buffer.sv
module cfgmem_frame_buffer #(
    parameter int FRAME_BITS = 12,
    parameter int ADDR_W     = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  cfgmem_pkg::cfg_op_t   op,
    output logic [FRAME_BITS-1:0] payload,
    output logic [ADDR_W-1:0]     frame_num
);
    localparam int STR_W = FRAME_BITS + ADDR_W;

    logic [STR_W-1:0] str_q;

    // Serial in at bit 0; payload ends up above the frame number.
    always_ff @(posedge clk) begin
        if (rst) begin
            str_q <= '0;
        end else if (op.shift) begin
            str_q <= {str_q[STR_W-2:0], op.bit_in};
        end
    end

    assign payload   = str_q[STR_W-1:ADDR_W];
    assign frame_num = str_q[ADDR_W-1:0];

endmodule

// File: rtl/cfgmem_frame_decoder.sv
module cfgmem_frame_decoder #(
    parameter int NUM_FRAMES = 6,
    parameter int ADDR_W     = 3
) (
    input  logic [ADDR_W-1:0]     frame_num,
    input  cfgmem_pkg::cfg_op_t   op,
    output logic [NUM_FRAMES-1:0] load_sel
);
    // A clear overrides any load; numbers past the last frame match nothing.
    for (genvar k = 0; k < NUM_FRAMES; k++) begin : g_dec
        assign load_sel[k] = op.write && !op.clear && (frame_num == ADDR_W'(k));
    end

endmodule

// File: rtl/cfgmem_frame_cell.sv
module cfgmem_frame_cell #(
    parameter int FRAME_BITS = 12
) (
    input  logic                  clk,
    input  logic                  load,
    input  logic                  clear,
    input  logic [FRAME_BITS-1:0] bus,
    output logic [FRAME_BITS-1:0] bits
);
    // No reset: configuration survives a loader reset.
    always_ff @(posedge clk) begin
        if (clear) begin
            bits <= '0;
        end else if (load) begin
            bits <= bus;
        end
    end

endmodule

// File: rtl/cfgmem_loader.sv
module cfgmem_loader #(
    parameter int NUM_FRAMES = 6,
    parameter int FRAME_BITS = 12
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             shift_en,
    input  logic                             shift_in,
    input  logic                             write_en,
    input  logic                             clear_all,
    output logic [NUM_FRAMES*FRAME_BITS-1:0] cfg_out
);
    import cfgmem_pkg::*;

    localparam int ADDR_W = frame_addr_width(NUM_FRAMES);

    cfg_op_t                 op;
    logic [FRAME_BITS-1:0]   buf_data;
    logic [ADDR_W-1:0]       buf_addr;
    logic [NUM_FRAMES-1:0]   wr_sel;

    assign op = '{shift: shift_en, bit_in: shift_in, write: write_en, clear: clear_all};

    cfgmem_frame_buffer #(
        .FRAME_BITS (FRAME_BITS),
        .ADDR_W     (ADDR_W)
    ) u_buffer (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .payload    (buf_data),
        .frame_num  (buf_addr)
    );

    cfgmem_frame_decoder #(
        .NUM_FRAMES (NUM_FRAMES),
        .ADDR_W     (ADDR_W)
    ) u_decoder (
        .frame_num  (buf_addr),
        .op         (op),
        .load_sel   (wr_sel)
    );

    for (genvar k = 0; k < NUM_FRAMES; k++) begin : g_frame
        cfgmem_frame_cell #(
            .FRAME_BITS (FRAME_BITS)
        ) u_cell (
            .clk   (clk),
            .load  (wr_sel[k]),
            .clear (op.clear),
            .bus   (buf_data),
            .bits  (cfg_out[k*FRAME_BITS +: FRAME_BITS])
        );
    end

endmodule

// File: rtl/cfgmem_loader_chk.sv
module cfgmem_loader_chk #(
    parameter int NF = 6,
    parameter int N  = 12,
    parameter int AW = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            shift_en,
    input logic            shift_in,
    input logic            write_en,
    input logic            clear_all,
    input logic [NF-1:0]   sel,
    input logic [N-1:0]    buf_data,
    input logic [AW-1:0]   buf_addr,
    input logic [NF*N-1:0] cfg_out
);
    // R1: the serial bit lands in the low end of the buffer
    a_r1_shift_entry: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> buf_addr[0] == $past(shift_in));

    // R3: no more than one frame enabled per write
    a_r3_single_load: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    // R5: a frame number past the last frame enables nothing
    a_r5_out_of_range: assert property (@(posedge clk) disable iff (rst)
        (write_en && int'(buf_addr) >= NF) |-> sel == '0);

    // R6: clear empties every frame
    a_r6_clear_all: assert property (@(posedge clk) disable iff (rst)
        clear_all |=> cfg_out == '0);

    for (genvar k = 0; k < NF; k++) begin : g_chk
        // R2: the enabled frame captures the payload bus
        a_r2_capture: assert property (@(posedge clk) disable iff (rst)
            (sel[k] && !clear_all) |=> cfg_out[k*N +: N] == $past(buf_data));
        // R4: frames without an enable keep their value
        a_r4_hold: assert property (@(posedge clk) disable iff (rst)
            (!sel[k] && !clear_all) |=> $stable(cfg_out[k*N +: N]));
    end

endmodule

bind cfgmem_loader cfgmem_loader_chk #(
    .NF (NUM_FRAMES),
    .N  (FRAME_BITS),
    .AW (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (shift_en),
    .shift_in  (shift_in),
    .write_en  (write_en),
    .clear_all (clear_all),
    .sel       (wr_sel),
    .buf_data  (buf_data),
    .buf_addr  (buf_addr),
    .cfg_out   (cfg_out)
);

// File: tb/tb_cfgmem_loader.sv
module tb_cfgmem_loader;
    localparam int NF = 6;
    localparam int N  = 12;
    localparam int AW = 3;
    localparam int W  = N + AW;

    logic clk = 1'b0;
    logic rst, shift_en, shift_in, write_en, clear_all;
    logic [NF*N-1:0] cfg_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] bm;          // expected buffer
    logic [N-1:0] fm [NF];     // expected frames

    always #2 clk = ~clk;      // 250 MHz

    cfgmem_loader #(.NUM_FRAMES(NF), .FRAME_BITS(N)) dut (
        .clk(clk), .rst(rst), .shift_en(shift_en), .shift_in(shift_in),
        .write_en(write_en), .clear_all(clear_all), .cfg_out(cfg_out)
    );

    function automatic logic [N-1:0] pat(input int k);
        return N'(k * 12'h2d7 + 12'h13c);
    endfunction

    // One clock of stimulus; expected state follows the requirements.
    task automatic step(input logic sh, input logic sb, input logic wr, input logic clr);
        shift_en = sh; shift_in = sb; write_en = wr; clear_all = clr;
        @(posedge clk);
        if (clr) begin
            for (int k = 0; k < NF; k++) fm[k] = '0;
        end else if (wr && int'(bm[AW-1:0]) < NF) begin
            fm[int'(bm[AW-1:0])] = bm[W-1:AW];
        end
        if (sh) bm = {bm[W-2:0], sb};
        @(negedge clk);
        shift_en = 0; shift_in = 0; write_en = 0; clear_all = 0;
    endtask

    task automatic shift_string(input int idx, input logic [N-1:0] data);
        for (int i = N-1; i >= 0; i--) step(1, data[i], 0, 0);
        for (int i = AW-1; i >= 0; i--) step(1, idx[i], 0, 0);
    endtask

    task automatic load_frame(input int idx, input logic [N-1:0] data);
        shift_string(idx, data);
        step(0, 0, 1, 0);
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (2) @(posedge clk);
        bm = '0;
        @(negedge clk);
        rst = 0;
    endtask

    task automatic check_frames(input string tag);
        for (int k = 0; k < NF; k++) begin
            checks++;
            if (cfg_out[k*N +: N] !== fm[k]) begin
                fails++;
                $display("FAIL %s frame %0d: actual %h expected %h", tag, k, cfg_out[k*N +: N], fm[k]);
            end
        end
    endtask

    task automatic check_one(input string tag, input int k, input logic [N-1:0] exp);
        checks++;
        if (cfg_out[k*N +: N] !== exp) begin
            fails++;
            $display("FAIL %s frame %0d: actual %h expected %h", tag, k, cfg_out[k*N +: N], exp);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst = 1; shift_en = 0; shift_in = 0; write_en = 0; clear_all = 0;
        bm = '0;
        for (int k = 0; k < NF; k++) fm[k] = '0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R6: clear brings all frames to zero
        step(0, 0, 0, 1);
        check_frames("R6 initial clear");

        // R1: first payload bit lands in the top frame bit, address MSB first
        load_frame(1, N'(1) << (N-1));
        check_one("R1 bit order", 1, N'(1) << (N-1));
        check_one("R1 other frame untouched", 0, '0);

        // R2 R4: distinct pattern per frame, all read back
        for (int k = 0; k < NF; k++) load_frame(k, pat(k));
        check_frames("R2 R4 all frames");
        check_one("R2 explicit frame 4", 4, pat(4));

        // R5: numbers 6 and 7 name no frame
        load_frame(6, 12'hfff);
        check_frames("R5 address 6");
        load_frame(7, 12'h0f0);
        check_frames("R5 address 7");

        // R8: write in the shift cycle uses the pre-shift payload
        shift_string(2, 12'h5a3);
        step(1, 1, 1, 0);
        check_one("R8 pre-shift payload", 2, 12'h5a3);
        check_frames("R8 all frames");

        // R3: repeated write with held buffer touches only one frame
        load_frame(3, 12'h777);
        step(0, 0, 1, 0);
        check_frames("R3 single frame per write");

        // R6: clear beats a same-cycle write
        shift_string(3, 12'habc);
        step(0, 0, 1, 1);
        check_frames("R6 clear priority");
        check_one("R6 frame 3 zero", 3, '0);

        // R7: reset keeps frames, empties buffer
        for (int k = 0; k < NF; k++) load_frame(k, ~pat(k));
        shift_string(5, 12'h9e1);
        do_reset();
        check_frames("R7 frames kept over reset");
        step(0, 0, 1, 0);
        check_one("R7 empty buffer writes frame 0", 0, '0);
        check_frames("R7 after write");

        // Random mix of shifts, writes and clears
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom_range(0, 99));
            logic sh = (r < 75);
            logic wr = (r >= 60 && r < 90) || (r >= 98);
            logic cl = (r == 99);
            step(sh, 1'($urandom), wr, cl);
            if (wr || cl) check_frames("R2 R4 R5 R8 random");
        end
        check_frames("R4 random final");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule